// File: doc/BRIEF.md
# UART FIFO Control and Trigger Logic

This block sits between a UART channel's host side and its serial side. It holds two byte-wide first-in first-out queues, one for characters waiting to be transmitted and one for characters received. It also holds the write-only control register that governs them. The host programs the control register through a single write port. Characters enter and leave each queue through push and pop strobes. The serial shift registers, the baud generator, line status and interrupt prioritisation all live outside this block.

The control register has several fields. One bit enables both queues, and two self-clearing bits flush the receive or transmit queue. A mode bit changes the meaning of the two ready outputs for DMA-style transfers, and two 2-bit fields select trigger levels. Both trigger fields index one shared level table. The transmit trigger field is writable only while the enhanced-feature input is high. From queue occupancy and the selected levels the block raises a transmit interrupt request, a receive interrupt request and the two ready outputs. One-cycle flags report pushes that were dropped and pops that found nothing.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset the queues are disabled, the mode bit is 0, both trigger codes are 0, both counts are 0, `txIrq` and `txReady` are 1, and `rxIrq` and `rxReady` are 0.
- R2: Every control write loads data bit 0 into `fifoEnable`. Bits 7:1 take effect only when bit 0 of the same write is 1.
- R3: A control write that changes `fifoEnable` empties both queues. While disabled, each queue holds at most one character.
- R4: A write with bit 0 and bit 1 set empties the receive queue. A write with bit 0 and bit 2 set empties the transmit queue. Neither bit needs to be written back to 0, the other fields of the same write still apply, and a push in the same cycle is lost.
- R5: Bit 3, written with bit 0 set, sets `dmaMode` (1 = DMA mode, 0 = normal).
- R6: Bits 7:6 select the receive trigger and bits 5:4 the transmit trigger. Both use the same table, in which codes 0, 1, 2 and 3 mean 1, 4, 8 and 14 characters.
- R7: Bits 5:4 change only when `enhEn` is 1 during the write. Otherwise the transmit trigger keeps its value.
- R8: `rxIrq` is 1 exactly when `rxCount` is at or above the receive trigger level.
- R9: `txIrq` is 1 exactly when `txCount` is below the transmit trigger level, which includes the empty queue.
- R10: Each queue is DEPTH (16) entries deep and pops characters in push order. A push and a pop in the same cycle both take effect unless the queue is full (the push is lost) or empty (the pop underflows).
- R11: A push to a full queue is dropped, leaves the count unchanged and raises that queue's overflow output for exactly the following cycle.
- R12: A pop from an empty queue leaves the pop data at its last value and raises that queue's underflow output for exactly the following cycle.
- R13: In normal mode `rxReady` means at least one character is held and `txReady` means at least one free slot. In DMA mode `rxReady` means the receive trigger has been reached and `txReady` means the free slots are at least the transmit trigger level.
- R14: Counts, pop data, interrupts, ready outputs and flags show the effect of a strobe or write just after the clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Control register write strobe |
| cfgWrData | input | 8 | Control register write data |
| enhEn | input | 1 | Enhanced-feature enable, gates bits 5:4 |
| txPush | input | 1 | Push strobe into the transmit queue |
| txPushData | input | 8 | Character to push into the transmit queue |
| txPop | input | 1 | Pop strobe from the transmit queue |
| txPopData | output | 8 | Last character popped from the transmit queue |
| rxPush | input | 1 | Push strobe into the receive queue |
| rxPushData | input | 8 | Character to push into the receive queue |
| rxPop | input | 1 | Pop strobe from the receive queue |
| rxPopData | output | 8 | Last character popped from the receive queue |
| txCount | output | 5 | Characters held in the transmit queue |
| rxCount | output | 5 | Characters held in the receive queue |
| fifoEnable | output | 1 | Queue enable bit |
| dmaMode | output | 1 | DMA mode bit |
| txIrq | output | 1 | Transmit interrupt request |
| rxIrq | output | 1 | Receive interrupt request |
| txReady | output | 1 | Transmit ready |
| rxReady | output | 1 | Receive ready |
| txOverflow | output | 1 | Transmit push dropped, one cycle |
| txUnderflow | output | 1 | Transmit pop on empty, one cycle |
| rxOverflow | output | 1 | Receive push dropped, one cycle |
| rxUnderflow | output | 1 | Receive pop on empty, one cycle |

## Verification
The bench builds the block with its defaults, DEPTH of 16 and WIDTH of 8. With those values a queue can be filled and overrun within a few dozen strobes, and the largest trigger level of 14 lies below full, so crossing a threshold is a different event from reaching full. The small depth also lets the bench pass the highest level and then overflow in the same sequence, and it lets the disabled one-entry mode be compared against the full depth.

// File: rtl/uart_fifo_pkg.sv
package uart_fifo_pkg;

  // Strobes from the control register to the queue datapath
  typedef struct packed {
    logic txClr;   // empty the transmit queue this cycle
    logic rxClr;   // empty the receive queue this cycle
    logic capOne;  // queues limited to one entry
  } fifoStrobes_t;

  // Shared trigger table for both directions
  function automatic int unsigned trigLevel(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/fifo_ctrl_regs.sv
module fifo_ctrl_regs
  import uart_fifo_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgWrEn,
  input  logic [7:0]   cfgWrData,
  input  logic         enhEn,
  output fifoStrobes_t strobes,
  output logic         fifoEnable,
  output logic         dmaMode,
  output logic [1:0]   txTrig,
  output logic [1:0]   rxTrig
);

  logic enChange;
  logic fieldWr;

  always_comb begin
    enChange       = cfgWrEn && (cfgWrData[0] != fifoEnable);
    fieldWr        = cfgWrEn && cfgWrData[0];
    strobes.rxClr  = enChange || (fieldWr && cfgWrData[1]);
    strobes.txClr  = enChange || (fieldWr && cfgWrData[2]);
    strobes.capOne = !fifoEnable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fifoEnable <= 1'b0;
      dmaMode    <= 1'b0;
      txTrig     <= 2'd0;
      rxTrig     <= 2'd0;
    end else if (cfgWrEn) begin
      fifoEnable <= cfgWrData[0];
      if (cfgWrData[0]) begin
        dmaMode <= cfgWrData[3];
        rxTrig  <= cfgWrData[7:6];
        if (enhEn) txTrig <= cfgWrData[5:4];
      end
    end
  end

endmodule

// File: rtl/fifo_lane.sv
module fifo_lane #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             capOne,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [CNT_W-1:0] count,
  output logic             overflow,
  output logic             underflow
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] cap;
  logic full, empty, pushOk, popOk;

  always_comb begin
    cap    = capOne ? CNT_W'(1) : CNT_W'(DEPTH);
    full   = count >= cap;
    empty  = count == '0;
    pushOk = push && !full && !clr;
    popOk  = pop && !empty && !clr;
  end

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      count     <= '0;
      popData   <= '0;
      overflow  <= 1'b0;
      underflow <= 1'b0;
    end else begin
      overflow  <= push && full && !clr;
      underflow <= pop && empty && !clr;
      if (clr) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (pushOk) wrPtr <= (wrPtr == PTR_LAST) ? '0 : wrPtr + 1'b1;
        if (popOk) begin
          popData <= mem[rdPtr];
          rdPtr   <= (rdPtr == PTR_LAST) ? '0 : rdPtr + 1'b1;
        end
        count <= count + CNT_W'(pushOk) - CNT_W'(popOk);
      end
    end
  end

endmodule

// File: rtl/fifo_datapath.sv
module fifo_datapath
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strobes,
  input  logic             dmaMode,
  input  logic [1:0]       txTrig,
  input  logic [1:0]       rxTrig,
  input  logic             txPush,
  input  logic [WIDTH-1:0] txPushData,
  input  logic             txPop,
  output logic [WIDTH-1:0] txPopData,
  input  logic             rxPush,
  input  logic [WIDTH-1:0] rxPushData,
  input  logic             rxPop,
  output logic [WIDTH-1:0] rxPopData,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic             txIrq,
  output logic             rxIrq,
  output logic             txReady,
  output logic             rxReady,
  output logic             txOverflow,
  output logic             txUnderflow,
  output logic             rxOverflow,
  output logic             rxUnderflow
);

  localparam int LANES = 2;  // lane 0 transmit, lane 1 receive

  logic [LANES-1:0] laneClr, lanePush, lanePop, laneOvf, laneUnf;
  logic [WIDTH-1:0] lanePushD [LANES];
  logic [WIDTH-1:0] lanePopD  [LANES];
  logic [CNT_W-1:0] laneCnt   [LANES];

  assign laneClr      = {strobes.rxClr, strobes.txClr};
  assign lanePush     = {rxPush, txPush};
  assign lanePop      = {rxPop, txPop};
  assign lanePushD[0] = txPushData;
  assign lanePushD[1] = rxPushData;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    fifo_lane #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_lane (
      .clk      (clk),
      .rstN     (rstN),
      .clr      (laneClr[g]),
      .capOne   (strobes.capOne),
      .push     (lanePush[g]),
      .pushData (lanePushD[g]),
      .pop      (lanePop[g]),
      .popData  (lanePopD[g]),
      .count    (laneCnt[g]),
      .overflow (laneOvf[g]),
      .underflow(laneUnf[g])
    );
  end

  logic [CNT_W-1:0] txLevel, rxLevel, cap, txFree;

  always_comb begin
    txPopData   = lanePopD[0];
    rxPopData   = lanePopD[1];
    txCount     = laneCnt[0];
    rxCount     = laneCnt[1];
    txOverflow  = laneOvf[0];
    rxOverflow  = laneOvf[1];
    txUnderflow = laneUnf[0];
    rxUnderflow = laneUnf[1];
    txLevel     = CNT_W'(trigLevel(txTrig));
    rxLevel     = CNT_W'(trigLevel(rxTrig));
    cap         = strobes.capOne ? CNT_W'(1) : CNT_W'(DEPTH);
    txFree      = cap - txCount;
    txIrq       = txCount < txLevel;
    rxIrq       = rxCount >= rxLevel;
    rxReady     = dmaMode ? rxIrq : (rxCount != '0);
    txReady     = dmaMode ? (txFree >= txLevel) : (txFree != '0);
  end

endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgWrData,
  input  logic             enhEn,
  input  logic             txPush,
  input  logic [WIDTH-1:0] txPushData,
  input  logic             txPop,
  output logic [WIDTH-1:0] txPopData,
  input  logic             rxPush,
  input  logic [WIDTH-1:0] rxPushData,
  input  logic             rxPop,
  output logic [WIDTH-1:0] rxPopData,
  output logic [CNT_W-1:0] txCount,
  output logic [CNT_W-1:0] rxCount,
  output logic             fifoEnable,
  output logic             dmaMode,
  output logic             txIrq,
  output logic             rxIrq,
  output logic             txReady,
  output logic             rxReady,
  output logic             txOverflow,
  output logic             txUnderflow,
  output logic             rxOverflow,
  output logic             rxUnderflow
);

  fifoStrobes_t strobes;
  logic [1:0]   txTrig, rxTrig;

  fifo_ctrl_regs u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgWrData (cfgWrData),
    .enhEn     (enhEn),
    .strobes   (strobes),
    .fifoEnable(fifoEnable),
    .dmaMode   (dmaMode),
    .txTrig    (txTrig),
    .rxTrig    (rxTrig)
  );

  fifo_datapath #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_data (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .dmaMode    (dmaMode),
    .txTrig     (txTrig),
    .rxTrig     (rxTrig),
    .txPush     (txPush),
    .txPushData (txPushData),
    .txPop      (txPop),
    .txPopData  (txPopData),
    .rxPush     (rxPush),
    .rxPushData (rxPushData),
    .rxPop      (rxPop),
    .rxPopData  (rxPopData),
    .txCount    (txCount),
    .rxCount    (rxCount),
    .txIrq      (txIrq),
    .rxIrq      (rxIrq),
    .txReady    (txReady),
    .rxReady    (rxReady),
    .txOverflow (txOverflow),
    .txUnderflow(txUnderflow),
    .rxOverflow (rxOverflow),
    .rxUnderflow(rxUnderflow)
  );

endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgWrEn,
  input logic [7:0]       cfgWrData,
  input logic             rxPush,
  input logic             rxPop,
  input logic [WIDTH-1:0] rxPopData,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount,
  input logic             fifoEnable,
  input logic             dmaMode,
  input logic             txIrq,
  input logic             rxIrq,
  input logic             rxReady,
  input logic             rxOverflow,
  input logic             rxUnderflow
);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (txCount <= CNT_W'(DEPTH)) && (rxCount <= CNT_W'(DEPTH))); // R10

  AST_FIELD_IGNORE: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !cfgWrData[0]) |=> $stable(dmaMode)); // R2

  AST_RX_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWrData[0] && cfgWrData[1]) |=> (rxCount == '0)); // R4

  AST_TX_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && cfgWrData[0] && cfgWrData[2]) |=> (txCount == '0)); // R4

  AST_RX_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (rxCount == '0) |-> !rxIrq); // R8

  AST_TX_IRQ_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == '0) |-> txIrq); // R9

  AST_NO_OVERFLOW_GROWTH: assert property (@(posedge clk) disable iff (!rstN)
    (fifoEnable && !cfgWrEn && rxPush && !rxPop && rxCount == CNT_W'(DEPTH))
      |=> (rxOverflow && rxCount == CNT_W'(DEPTH))); // R11

  AST_UNDERFLOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    rxUnderflow |-> $stable(rxPopData)); // R12

  AST_READY_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaMode && rxCount != '0) |-> rxReady); // R13

endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_chk (.*);

// File: tb/uart_fifo_ctrl_bench.sv
module uart_fifo_ctrl_bench;

  localparam int DEPTH = 16;
  localparam int WIDTH = 8;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic enhEn = 1'b0;
  logic txPush = 1'b0, txPop = 1'b0, rxPush = 1'b0, rxPop = 1'b0;
  logic [WIDTH-1:0] txPushData = '0, rxPushData = '0;
  logic [WIDTH-1:0] txPopData, rxPopData;
  logic [CNT_W-1:0] txCount, rxCount;
  logic fifoEnable, dmaMode, txIrq, rxIrq, txReady, rxReady;
  logic txOverflow, txUnderflow, rxOverflow, rxUnderflow;

  int vectors = 0;
  int misses = 0;

  always #5 clk = ~clk;

  uart_fifo_ctrl #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_uart_fifo_ctrl (.*);

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // All drivers change just after a falling edge and return one cycle later
  task automatic cfgWr(input logic [7:0] d);
    cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pushRx(input logic [7:0] d);
    rxPush = 1'b1; rxPushData = d;
    @(negedge clk);
    rxPush = 1'b0;
  endtask

  task automatic pushTx(input logic [7:0] d);
    txPush = 1'b1; txPushData = d;
    @(negedge clk);
    txPush = 1'b0;
  endtask

  task automatic popRx();
    rxPop = 1'b1;
    @(negedge clk);
    rxPop = 1'b0;
  endtask

  task automatic popTx();
    txPop = 1'b1;
    @(negedge clk);
    txPop = 1'b0;
  endtask

  task automatic testReset();
    check("R1 fifoEnable", fifoEnable, 0);
    check("R1 dmaMode", dmaMode, 0);
    check("R1 txCount", txCount, 0);
    check("R1 rxCount", rxCount, 0);
    check("R1 txIrq", txIrq, 1);
    check("R1 rxIrq", rxIrq, 0);
    check("R1 txReady", txReady, 1);
    check("R1 rxReady", rxReady, 0);
  endtask

  task automatic testDisabled();
    pushRx(8'h11);
    check("R3 one entry count", rxCount, 1);
    check("R14 rxIrq at level one", rxIrq, 1);
    pushRx(8'h22);
    check("R3 second push dropped", rxCount, 1);
    check("R11 overflow when disabled", rxOverflow, 1);
    popRx();
    check("R3 held entry", rxPopData, 8'h11);
    check("R3 count after pop", rxCount, 0);
  endtask

  task automatic testIgnoreAndEnable();
    cfgWr(8'hC8);
    check("R2 enable stays low", fifoEnable, 0);
    check("R2 dma ignored", dmaMode, 0);
    pushRx(8'h33);
    cfgWr(8'h01);
    check("R2 enable set", fifoEnable, 1);
    check("R3 enable change clears", rxCount, 0);
    pushRx(8'h34);
    check("R6 rx trigger still one", rxIrq, 1);
  endtask

  task automatic testRxTrigger();
    cfgWr(8'h83);
    check("R4 rx clear", rxCount, 0);
    for (int i = 0; i < 7; i++) pushRx(8'h40 + 8'(i));
    check("R8 below level 8", rxIrq, 0);
    check("R6 count 7", rxCount, 7);
    pushRx(8'h47);
    check("R8 at level 8", rxIrq, 1);
    cfgWr(8'h83);
    check("R4 rx clear again", rxCount, 0);
    check("R8 irq after clear", rxIrq, 0);
  endtask

  task automatic testTxTrigger();
    enhEn = 1'b0;
    cfgWr(8'h31);
    pushTx(8'hA0);
    check("R7 tx trigger gated", txIrq, 0);
    enhEn = 1'b1;
    cfgWr(8'h21);
    check("R9 below level 8", txIrq, 1);
    for (int i = 1; i < 8; i++) pushTx(8'hA0 + 8'(i));
    check("R9 at level 8", txIrq, 0);
    popTx();
    check("R10 first out", txPopData, 8'hA0);
    check("R9 drop below", txIrq, 1);
    for (int i = 1; i < 8; i++) begin
      popTx();
      check("R10 order", txPopData, 8'hA0 + i);
    end
    check("R9 empty irq", txIrq, 1);
    pushTx(8'hB0);
    txPush = 1'b1; txPushData = 8'hB1; txPop = 1'b1;
    @(negedge clk);
    txPush = 1'b0; txPop = 1'b0;
    check("R10 push and pop count", txCount, 1);
    check("R10 push and pop data", txPopData, 8'hB0);
    popTx();
    check("R10 pushed in same cycle", txPopData, 8'hB1);
  endtask

  task automatic testFull();
    cfgWr(8'h03);
    for (int i = 0; i < DEPTH; i++) pushRx(8'(i * 3 + 1));
    check("R10 full count", rxCount, DEPTH);
    check("R11 no overflow yet", rxOverflow, 0);
    pushRx(8'hEE);
    check("R11 overflow pulse", rxOverflow, 1);
    check("R11 count held", rxCount, DEPTH);
    @(negedge clk);
    check("R11 pulse one cycle", rxOverflow, 0);
    for (int i = 0; i < DEPTH; i++) begin
      popRx();
      check("R10 full order", rxPopData, i * 3 + 1);
    end
    popRx();
    check("R12 underflow pulse", rxUnderflow, 1);
    check("R12 data held", rxPopData, (DEPTH - 1) * 3 + 1);
    @(negedge clk);
    check("R12 pulse one cycle", rxUnderflow, 0);
  endtask

  task automatic testDma();
    enhEn = 1'b1;
    cfgWr(8'hAD);
    check("R5 dma set", dmaMode, 1);
    check("R4 tx clear", txCount, 0);
    check("R13 dma tx free 16", txReady, 1);
    pushRx(8'h01);
    check("R13 dma rx below level", rxReady, 0);
    for (int i = 0; i < 7; i++) pushRx(8'h02);
    check("R13 dma rx at level", rxReady, 1);
    for (int i = 0; i < 9; i++) pushTx(8'h50);
    check("R13 dma tx free 7", txReady, 0);
    cfgWr(8'hA1);
    check("R5 dma cleared", dmaMode, 0);
    check("R13 normal tx free", txReady, 1);
    check("R13 normal rx held", rxReady, 1);
    cfgWr(8'hA5);
    check("R4 tx only clear", txCount, 0);
    check("R4 rx untouched", rxCount, 8);
    rxPush = 1'b1; rxPushData = 8'h77;
    cfgWr(8'hA3);
    rxPush = 1'b0;
    check("R4 clear beats push", rxCount, 0);
  endtask

  task automatic testDisable();
    pushRx(8'h61);
    pushRx(8'h62);
    pushTx(8'h63);
    cfgWr(8'h00);
    check("R2 enable cleared", fifoEnable, 0);
    check("R3 rx emptied", rxCount, 0);
    check("R3 tx emptied", txCount, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testIgnoreAndEnable();
    testRxTrigger();
    testTxTrigger();
    testFull();
    testDma();
    testDisable();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    vectors++;
    misses++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule